// File: doc/BRIEF.md
# Multi-Context Thread Enable Controller

This block keeps the scheduling state of an eight-context processing engine. Each context sits in one of three states (Sleep, Ready, Executing) and owns a program counter, a pending signal-event word and a wakeup mask. A host reaches the block through a small register port. Eight enable bits sit in bits 15:8 of the enable register. A pointer register picks which context the three indirect registers reach. A status register shows whether a context is running and which one.

A sleeping context becomes Ready as soon as its pending signal events overlap its wakeup mask. A round-robin arbiter moves one Ready, enabled context to Executing whenever the engine is idle. The search starts just after the last context that was granted. An executing context keeps running until the yield input fires, even if its enable bit is cleared in the meantime. On yield it drops back to Sleep with its pending events cleared. An event input ORs bits into one context's pending word.

Top module: `tec_thread_ctrl`

## Requirements
- R1: After reset every context is in Sleep with program counter, pending events and wakeup mask at zero, all enable bits clear, the pointer at 0, and exec_active low.
- R2: Byte offsets are: 0x00 enable, 0x04 pointer, 0x08 context status, 0x0C pending events, 0x10 wakeup mask, 0x14 active status (read-only). Any other offset reads 0. The enable register stores write-data bits 15:8 (bit 8+i enables context i) and reads them back in the same bits, with all other bits reading 0.
- R3: Writes and reads at 0x08, 0x0C and 0x10 address the context named by pointer bits 2:0. A write at 0x08 sets that context's 12-bit program counter. A read at 0x08 returns the program counter in bits 11:0 and the state in bits 17:16 (0 Sleep, 1 Ready, 2 Executing).
- R4: A context in Sleep whose pending events AND wakeup mask is non-zero is Ready one cycle later. Writing 1 to both the pending word and the mask therefore makes it Ready.
- R5: A Ready context moves to Executing only when its enable bit is set and no context is executing. The move happens at the clock edge after the arbiter sees it eligible.
- R6: The arbiter grants the first eligible context in the order after the last granted one, wrapping at 7. After reset the search starts at context 0.
- R7: Clearing an enable bit never stops an executing context; it keeps Executing until a yield.
- R8: A yield while a context executes returns that context to Sleep at the next edge and clears its pending events. A yield while no context executes has no effect.
- R9: With ev_valid high, ev_bits are ORed into the pending events of context ev_ctx at the next edge. In the same cycle they are ORed on top of any host write to that word.
- R10: The active-status read gives bit 31 = a context is executing and bits 2:0 = its number; it reads 0 when idle. While active, exec_pc equals the executing context's program counter.
- R11: At most one context is Executing at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset for reads and writes |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr, combinational |
| yield_i | input | 1 | The executing context gives up the engine |
| ev_valid | input | 1 | Signal event strobe |
| ev_ctx | input | 3 | Context that receives the event |
| ev_bits | input | 16 | Event bits ORed into the pending word |
| exec_active | output | 1 | A context is executing |
| exec_ctx | output | 3 | Number of the executing context, 0 when idle |
| exec_pc | output | 12 | Program counter of the executing context |

## Verification
The bench first disables an executing context and checks that it stays active for several cycles. A design that preempted on the enable write would show the status go idle or switch contexts. It then checks grants with Ready contexts on both sides of the last winner. A fixed-priority or off-by-one arbiter would pick context 0 or 1 instead of 3. A yield while idle and an event arriving on a sleeping context are also covered, so a design that cleared the wrong pending word or woke on the mask alone would show a wrong state field. A long random phase mixes writes, events and yields and compares every cycle against a behavioural model. This exposes same-cycle collisions such as a host write racing a yield clear.

// File: rtl/tec_pkg.sv
package tec_pkg;
   typedef enum logic [1:0] {
      CTX_SLEEP = 2'd0,
      CTX_READY = 2'd1,
      CTX_EXEC  = 2'd2
   } ctx_state_e;

   localparam logic [7:0] OFS_ENABLE = 8'h00;
   localparam logic [7:0] OFS_PTR    = 8'h04;
   localparam logic [7:0] OFS_CSTAT  = 8'h08;
   localparam logic [7:0] OFS_SIGEV  = 8'h0C;
   localparam logic [7:0] OFS_WAKE   = 8'h10;
   localparam logic [7:0] OFS_ACTIVE = 8'h14;

   localparam int EN_LSB      = 8;
   localparam int STATE_LSB   = 16;
   localparam int ACTIVE_BIT  = 31;
endpackage

// File: rtl/tec_ctx_slot.sv
module tec_ctx_slot
   import tec_pkg::*;
#(
   parameter int PC_W   = 12,
   parameter int EVT_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pc,
   input  logic              wr_sig,
   input  logic              wr_wake,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ev_hit,
   input  logic [EVT_W-1:0]  ev_bits,
   input  logic              grant,
   input  logic              yield_i,
   output ctx_state_e        state_o,
   output logic [PC_W-1:0]   pc_o,
   output logic [EVT_W-1:0]  sig_o,
   output logic [EVT_W-1:0]  wake_o
);
   if (PC_W > DATA_W || EVT_W > DATA_W) begin : g_bad_width
      $error("tec_ctx_slot: field wider than data word");
   end

   ctx_state_e        state_q, state_d;
   logic [PC_W-1:0]   pc_q;
   logic [EVT_W-1:0]  sig_q, sig_d, wake_q;
   logic              leaving;

   assign leaving = (state_q == CTX_EXEC) && yield_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CTX_SLEEP: if ((sig_q & wake_q) != '0) state_d = CTX_READY;
         CTX_READY: if (grant)                  state_d = CTX_EXEC;
         CTX_EXEC:  if (yield_i)                state_d = CTX_SLEEP;
         default:                               state_d = CTX_SLEEP;
      endcase
   end

   always_comb begin
      if (wr_sig)       sig_d = wdata[EVT_W-1:0];
      else if (leaving) sig_d = '0;
      else              sig_d = sig_q;
      if (ev_hit)       sig_d = sig_d | ev_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CTX_SLEEP;
         pc_q    <= '0;
         sig_q   <= '0;
         wake_q  <= '0;
      end else begin
         state_q <= state_d;
         sig_q   <= sig_d;
         if (wr_pc)   pc_q   <= wdata[PC_W-1:0];
         if (wr_wake) wake_q <= wdata[EVT_W-1:0];
      end
   end

   assign state_o = state_q;
   assign pc_o    = pc_q;
   assign sig_o   = sig_q;
   assign wake_o  = wake_q;

   // R8
   yield_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CTX_EXEC && yield_i) |=> (state_q == CTX_SLEEP));

   // R4
   wake_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CTX_SLEEP && (sig_q & wake_q) != '0) |=> (state_q == CTX_READY));

   // R7
   exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CTX_EXEC && !yield_i) |=> (state_q == CTX_EXEC));
endmodule

// File: rtl/tec_rr_arbiter.sv
module tec_rr_arbiter #(
   parameter int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic [IDX_W-1:0] last_idx,
   output logic             gnt_valid,
   output logic [IDX_W-1:0] gnt_idx
);
   if (N < 2) begin : g_bad_n
      $error("tec_rr_arbiter: need at least two requesters");
   end

   always_comb begin
      int idx;
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int k = N; k >= 1; k--) begin
         idx = (int'(last_idx) + k) % N;
         if (req[idx]) begin
            gnt_valid = 1'b1;
            gnt_idx   = IDX_W'(idx);
         end
      end
   end

   logic [IDX_W-1:0] after_last;
   assign after_last = (int'(last_idx) == N - 1) ? '0 : last_idx + 1'b1;

   // R6
   rr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[after_last] |-> (gnt_valid && gnt_idx == after_last));

   // R5
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> !gnt_valid);
endmodule

// File: rtl/tec_thread_ctrl.sv
module tec_thread_ctrl
   import tec_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter int PC_W    = 12,
   parameter int EVT_W   = 16,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = $clog2(NUM_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              yield_i,
   input  logic              ev_valid,
   input  logic [IDX_W-1:0]  ev_ctx,
   input  logic [EVT_W-1:0]  ev_bits,
   output logic              exec_active,
   output logic [IDX_W-1:0]  exec_ctx,
   output logic [PC_W-1:0]   exec_pc
);
   if (NUM_CTX < 2 || NUM_CTX > 8) begin : g_bad_ctx
      $error("tec_thread_ctrl: enable field holds 2 to 8 contexts");
   end
   if (PC_W > STATE_LSB) begin : g_bad_pc
      $error("tec_thread_ctrl: program counter overlaps state field");
   end
   if (DATA_W != 32 || ADDR_W < 8) begin : g_bad_bus
      $error("tec_thread_ctrl: register port must be 32 bits with 8-bit offsets");
   end

   logic [NUM_CTX-1:0] en_q;
   logic [IDX_W-1:0]   ptr_q;
   logic [IDX_W-1:0]   last_q;

   ctx_state_e         st_arr   [NUM_CTX];
   logic [PC_W-1:0]    pc_arr   [NUM_CTX];
   logic [EVT_W-1:0]   sig_arr  [NUM_CTX];
   logic [EVT_W-1:0]   wake_arr [NUM_CTX];
   logic [NUM_CTX-1:0] exec_vec, ready_vec, req_vec, grant_vec;
   logic               gnt_valid;
   logic [IDX_W-1:0]   gnt_idx;

   logic wr_en_reg, wr_ptr, wr_cstat, wr_sigev, wr_wake;
   assign wr_en_reg = csr_we && (csr_addr == ADDR_W'(OFS_ENABLE));
   assign wr_ptr    = csr_we && (csr_addr == ADDR_W'(OFS_PTR));
   assign wr_cstat  = csr_we && (csr_addr == ADDR_W'(OFS_CSTAT));
   assign wr_sigev  = csr_we && (csr_addr == ADDR_W'(OFS_SIGEV));
   assign wr_wake   = csr_we && (csr_addr == ADDR_W'(OFS_WAKE));

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
      logic sel;
      assign sel = (ptr_q == IDX_W'(i));

      tec_ctx_slot #(
         .PC_W   (PC_W),
         .EVT_W  (EVT_W),
         .DATA_W (DATA_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_pc   (wr_cstat && sel),
         .wr_sig  (wr_sigev && sel),
         .wr_wake (wr_wake && sel),
         .wdata   (csr_wdata),
         .ev_hit  (ev_valid && ev_ctx == IDX_W'(i)),
         .ev_bits (ev_bits),
         .grant   (grant_vec[i]),
         .yield_i (yield_i),
         .state_o (st_arr[i]),
         .pc_o    (pc_arr[i]),
         .sig_o   (sig_arr[i]),
         .wake_o  (wake_arr[i])
      );

      assign exec_vec[i]  = (st_arr[i] == CTX_EXEC);
      assign ready_vec[i] = (st_arr[i] == CTX_READY);
      assign grant_vec[i] = gnt_valid && (gnt_idx == IDX_W'(i));

      // R5
      enabled_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (exec_vec[i] && !$past(exec_vec[i])) |-> $past(en_q[i]));
   end

   assign exec_active = |exec_vec;
   assign req_vec     = exec_active ? '0 : (ready_vec & en_q);

   tec_rr_arbiter #(.N(NUM_CTX)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_vec),
      .last_idx  (last_q),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   always_comb begin
      exec_ctx = '0;
      for (int i = 0; i < NUM_CTX; i++) begin
         if (exec_vec[i]) exec_ctx = IDX_W'(i);
      end
   end

   assign exec_pc = pc_arr[exec_ctx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         ptr_q  <= '0;
         last_q <= IDX_W'(NUM_CTX - 1);
      end else begin
         if (wr_en_reg) en_q  <= csr_wdata[EN_LSB +: NUM_CTX];
         if (wr_ptr)    ptr_q <= csr_wdata[IDX_W-1:0];
         if (gnt_valid) last_q <= gnt_idx;
      end
   end

   always_comb begin
      csr_rdata = '0;
      case (csr_addr)
         ADDR_W'(OFS_ENABLE): csr_rdata[EN_LSB +: NUM_CTX] = en_q;
         ADDR_W'(OFS_PTR):    csr_rdata[IDX_W-1:0] = ptr_q;
         ADDR_W'(OFS_CSTAT): begin
            csr_rdata[PC_W-1:0]          = pc_arr[ptr_q];
            csr_rdata[STATE_LSB +: 2]    = st_arr[ptr_q];
         end
         ADDR_W'(OFS_SIGEV):  csr_rdata[EVT_W-1:0] = sig_arr[ptr_q];
         ADDR_W'(OFS_WAKE):   csr_rdata[EVT_W-1:0] = wake_arr[ptr_q];
         ADDR_W'(OFS_ACTIVE): begin
            csr_rdata[ACTIVE_BIT] = exec_active;
            csr_rdata[IDX_W-1:0]  = exec_ctx;
         end
         default: csr_rdata = '0;
      endcase
   end

   // R11
   single_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(exec_vec));

   // R7
   no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_active && !yield_i) |=> (exec_active && $stable(exec_ctx)));

   // R8
   idle_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_active && yield_i && req_vec == '0) |=> !exec_active);
endmodule

// File: tb/tb_tec_thread_ctrl.sv
`timescale 1ns/1ps
module tb_tec_thread_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [7:0]  csr_addr = 8'h00;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        yield_i = 1'b0;
   logic        ev_valid = 1'b0;
   logic [2:0]  ev_ctx = '0;
   logic [15:0] ev_bits = '0;
   logic        exec_active;
   logic [2:0]  exec_ctx;
   logic [11:0] exec_pc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tec_thread_ctrl dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .yield_i(yield_i),
      .ev_valid(ev_valid), .ev_ctx(ev_ctx), .ev_bits(ev_bits),
      .exec_active(exec_active), .exec_ctx(exec_ctx), .exec_pc(exec_pc)
   );

   // behavioural reference: 0 sleep, 1 ready, 2 executing
   int m_st[8], m_pc[8], m_sig[8], m_wk[8];
   int m_en, m_ptr, m_last;

   function automatic int m_running();
      for (int i = 0; i < 8; i++) if (m_st[i] == 2) return i;
      return -1;
   endfunction

   function automatic logic [31:0] m_read(logic [7:0] a);
      int r;
      r = m_running();
      case (a)
         8'h00: return 32'(m_en) << 8;
         8'h04: return 32'(m_ptr);
         8'h08: return (32'(m_st[m_ptr]) << 16) | 32'(m_pc[m_ptr]);
         8'h0C: return 32'(m_sig[m_ptr]);
         8'h10: return 32'(m_wk[m_ptr]);
         8'h14: return (r < 0) ? 32'h0 : (32'h8000_0000 | 32'(r));
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_st[i] = 0; m_pc[i] = 0; m_sig[i] = 0; m_wk[i] = 0;
         end
         m_en = 0; m_ptr = 0; m_last = 7;
      end else begin
         int run, pick;
         int ost[8];
         run = m_running();
         pick = -1;
         if (run < 0) begin
            for (int k = 1; k <= 8; k++) begin
               int c;
               c = (m_last + k) % 8;
               if (pick < 0 && m_st[c] == 1 && ((m_en >> c) & 1) == 1) pick = c;
            end
         end
         for (int i = 0; i < 8; i++) ost[i] = m_st[i];
         for (int i = 0; i < 8; i++) begin
            if (ost[i] == 2 && yield_i) begin
               m_st[i] = 0;
               m_sig[i] = 0;
            end else if (ost[i] == 0 && (m_sig[i] & m_wk[i]) != 0) begin
               m_st[i] = 1;
            end else if (ost[i] == 1 && pick == i) begin
               m_st[i] = 2;
            end
            if (csr_we && csr_addr == 8'h0C && m_ptr == i) m_sig[i] = int'(csr_wdata[15:0]);
            if (ev_valid && int'(ev_ctx) == i) m_sig[i] = m_sig[i] | int'(ev_bits);
            if (csr_we && csr_addr == 8'h08 && m_ptr == i) m_pc[i] = int'(csr_wdata[11:0]);
            if (csr_we && csr_addr == 8'h10 && m_ptr == i) m_wk[i] = int'(csr_wdata[15:0]);
         end
         if (pick >= 0) m_last = pick;
         if (csr_we && csr_addr == 8'h00) m_en = int'(csr_wdata[15:8]);
         if (csr_we && csr_addr == 8'h04) m_ptr = int'(csr_wdata[2:0]);
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int r;
         r = m_running();
         chk("R11 exec_active", 32'(exec_active), (r >= 0) ? 32'd1 : 32'd0);
         chk("R5 exec_ctx", 32'(exec_ctx), (r >= 0) ? 32'(r) : 32'd0);
         if (r >= 0) chk("R10 exec_pc", 32'(exec_pc), 32'(m_pc[r]));
         chk("R2 csr_rdata", csr_rdata, m_read(csr_addr));
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      step();
      csr_we = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
      csr_addr = a;
      @(negedge clk);
      chk(req, csr_rdata, exp);
      step();
   endtask

   task automatic pulse_yield();
      yield_i = 1'b1;
      step();
      yield_i = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 exec_active", 32'(exec_active), 32'd0);
      step();
      rd_chk("R1 enable", 8'h00, 32'h0);
      rd_chk("R1 cstat", 8'h08, 32'h0);
      rd_chk("R2 unmapped", 8'h40, 32'h0);

      for (int i = 0; i < 4; i++) begin
         wr(8'h04, 32'(i));
         wr(8'h08, 32'h100 + 32'(i));
         wr(8'h0C, 32'h1);
         wr(8'h10, 32'h1);
      end
      wr(8'h04, 32'd4);
      wr(8'h08, 32'h104);
      wr(8'h0C, 32'h2);
      wr(8'h10, 32'h1);
      step();
      wr(8'h04, 32'd0);
      rd_chk("R3 R4 ctx0 ready", 8'h08, 32'h0001_0100);
      wr(8'h04, 32'd4);
      rd_chk("R4 ctx4 no overlap stays asleep", 8'h08, 32'h0000_0104);
      rd_chk("R5 nothing runs unenabled", 8'h14, 32'h0);

      wr(8'h00, 32'h0000_0600);
      step();
      rd_chk("R6 first grant ctx1", 8'h14, 32'h8000_0001);
      chk("R10 exec_pc ctx1", 32'(exec_pc), 32'h101);

      pulse_yield();
      step();
      rd_chk("R6 next grant ctx2", 8'h14, 32'h8000_0002);
      wr(8'h04, 32'd1);
      rd_chk("R8 yield clears events", 8'h0C, 32'h0);
      rd_chk("R8 yielded ctx sleeps", 8'h08, 32'h0000_0101);

      wr(8'h00, 32'h0);
      repeat (4) step();
      rd_chk("R7 disable keeps running", 8'h14, 32'h8000_0002);

      pulse_yield();
      step();
      rd_chk("R8 idle after yield", 8'h14, 32'h0);
      pulse_yield();
      wr(8'h04, 32'd0);
      rd_chk("R8 idle yield ignored", 8'h08, 32'h0001_0100);

      ev_valid = 1'b1; ev_ctx = 3'd1; ev_bits = 16'h0001;
      step();
      ev_valid = 1'b0;
      wr(8'h04, 32'd1);
      rd_chk("R9 event ORed", 8'h0C, 32'h1);
      rd_chk("R4 event wakes ctx1", 8'h08, 32'h0001_0101);

      wr(8'h00, 32'h0000_FF00);
      step();
      rd_chk("R6 round robin after ctx2 picks ctx3", 8'h14, 32'h8000_0003);
      chk("R10 exec_pc ctx3", 32'(exec_pc), 32'h103);
      rd_chk("R2 enable readback", 8'h00, 32'h0000_FF00);
      wr(8'h00, 32'hA5A5_5A5A);
      rd_chk("R2 enable field only", 8'h00, 32'h0000_5A00);
      wr(8'h04, 32'hFFFF_FFF9);
      rd_chk("R3 pointer low bits", 8'h04, 32'h1);

      for (int n = 0; n < 4000; n++) begin
         int dice;
         logic [7:0] addrs [6];
         addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14};
         dice = $urandom % 10;
         csr_we = 1'b0;
         csr_addr = addrs[$urandom % 6];
         csr_wdata = $urandom;
         if (dice < 3) begin
            csr_we = 1'b1;
            if (csr_addr == 8'h0C || csr_addr == 8'h10) csr_wdata = $urandom % 4;
         end
         yield_i  = ($urandom % 8) == 0;
         ev_valid = ($urandom % 6) == 0;
         ev_ctx   = 3'($urandom);
         ev_bits  = 16'($urandom % 4);
         step();
      end
      csr_we = 1'b0; yield_i = 1'b0; ev_valid = 1'b0;
      step();
      finish_run();
   end
endmodule